// File: doc/BRIEF.md
# Read Burst Latency Sequencer for a Four-Bank Synchronous DRAM

This block is the device-side read sequencer of a synchronous DRAM with four banks. It takes already decoded row-open, column-read and burst-stop commands with their bank, row and column fields. From one column-read it issues a column strobe with the column address on every beat of the burst. It also delays those beats by the programmed CAS latency to form the output-enable and output-column timing of the data bus.

Fixed bursts of 1, 2, 4 or 8 words stop by themselves and release the bus. A full-page burst keeps cycling through the columns of the open row until a stop command arrives. A column-read that hits a bank that is not open, or that comes too soon after the row was opened, is rejected. It raises a one-cycle error flag and produces no beats. Latency and burst length are loaded as a pair through a simple load strobe.

Top module: `rd_burst_seq`

## Requirements
- R1: Latency is 3 cycles after a load with `mode_cl3`=1 and 2 cycles otherwise, including after reset. If a read is sampled on clock edge k, the first word drives `dq_oe`=1 and `dq_col` in the cycle that starts at edge k+CL.
- R2: `mode_bl` sets the burst length: 0 gives 1 word, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. Codes 4 to 6 act as 1 word. A single read gives that many consecutive beats with no further command.
- R3: In bursts of 2, 4 or 8, each beat adds one to the column. Only the low log2(length) bits change, so the count wraps inside the aligned block of that size.
- R4: In fixed bursts, `dq_oe` drops in the cycle right after the last word and stays low while no new data is due.
- R5: A burst-stop sampled on edge k suppresses every beat from edge k on. Words already issued still come out. `dq_oe` is low from edge k+CL.
- R6: A full-page burst runs until a burst-stop arrives. Its column goes from 2^COL_W-1 back to 0 and keeps counting.
- R7: A valid read during an active burst cancels the old burst's remaining beats. The new burst's first word follows the old burst's last issued word with no idle cycle.
- R8: After a row-open on edge k, a read to that bank is accepted on edge k+TRCD or later. The four banks keep separate open state, open row and timer.
- R9: A read to a bank that is not open, or one sampled before edge k+TRCD, sets `rd_err` for the next cycle only. It issues no beat and leaves `dq_oe` low.
- R10: After an accepted read, `beat_vld` is high in the next cycle. In that cycle `beat_bank`, `beat_row` (the open row of that bank) and `beat_col` (the read column) are shown.
- R11: During and right after reset, `beat_vld`, `dq_oe` and `rd_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ld | input | 1 | Load latency and burst length |
| mode_cl3 | input | 1 | 1 selects latency 3, 0 selects latency 2 |
| mode_bl | input | 3 | Burst length code |
| cmd_act | input | 1 | Row-open command |
| cmd_rd | input | 1 | Column-read command |
| cmd_bst | input | 1 | Burst-stop command |
| cmd_bank | input | 2 | Bank of the command |
| cmd_row | input | 12 | Row for row-open |
| cmd_col | input | 10 | Start column for read |
| beat_vld | output | 1 | Column strobe for this cycle |
| beat_bank | output | 2 | Bank of the current beat |
| beat_row | output | 12 | Row of the current beat |
| beat_col | output | 10 | Column of the current beat |
| dq_oe | output | 1 | Data bus output enable |
| dq_col | output | 10 | Column whose word is on the bus |
| rd_err | output | 1 | Rejected read flag |

## Verification
The assertions assume that at most one of row-open, read and burst-stop is presented per cycle. They also assume the latency and length are loaded only while no burst is running and the latency pipeline is empty, because the stage tap and the block mask are taken live from the mode register. The stimulus meets both: it presents commands one at a time from tasks, and it loads a new mode only after the previous scenario has drained the bus. Full-page runs are always ended by an explicit stop.

// File: rtl/rb_pkg.sv
package rb_pkg;

  localparam logic [2:0] BLC_1  = 3'd0;
  localparam logic [2:0] BLC_2  = 3'd1;
  localparam logic [2:0] BLC_4  = 3'd2;
  localparam logic [2:0] BLC_8  = 3'd3;
  localparam logic [2:0] BLC_FP = 3'd7;

  // low-bit mask of a fixed burst: beats minus one
  function automatic logic [2:0] fixed_mask(input logic [2:0] code);
    case (code)
      BLC_2:   fixed_mask = 3'd1;
      BLC_4:   fixed_mask = 3'd3;
      BLC_8:   fixed_mask = 3'd7;
      default: fixed_mask = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/rb_bank_table.sv
module rb_bank_table #(
  parameter int NB    = 4,
  parameter int ROW_W = 12,
  parameter int TRCD  = 3,
  localparam int BW   = $clog2(NB),
  localparam int CW   = $clog2(TRCD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic [BW-1:0]    act_bank_i,
  input  logic [ROW_W-1:0] act_row_i,
  input  logic [BW-1:0]    q_bank_i,
  output logic             q_ready_o,
  output logic [ROW_W-1:0] q_row_o
);

  logic [NB-1:0]    ready;
  logic [ROW_W-1:0] rows [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic             on_q, on_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic             hit;

    assign hit = act_i && (act_bank_i == BW'(b));

    always_comb begin
      on_d  = on_q;
      row_d = row_q;
      cnt_d = cnt_q;
      if (hit) begin
        on_d  = 1'b1;
        row_d = act_row_i;
        cnt_d = CW'(1);
      end else if (on_q && (cnt_q != CW'(TRCD))) begin
        cnt_d = cnt_q + CW'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        on_q  <= 1'b0;
        row_q <= '0;
        cnt_q <= '0;
      end else begin
        on_q  <= on_d;
        row_q <= row_d;
        cnt_q <= cnt_d;
      end
    end

    assign ready[b] = on_q && (cnt_q == CW'(TRCD));
    assign rows[b]  = row_q;

    if (TRCD > 1) begin : g_chk
      // R8
      trcd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !ready[b]);
    end
  end

  assign q_ready_o = ready[q_bank_i];
  assign q_row_o   = rows[q_bank_i];

endmodule

// File: rtl/rb_col_gen.sv
module rb_col_gen #(
  parameter int NB    = 4,
  parameter int ROW_W = 12,
  parameter int COL_W = 10,
  localparam int BW   = $clog2(NB),
  localparam logic [COL_W-1:0] LAST_COL = {COL_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [2:0]       bl_code_i,
  input  logic [BW-1:0]    bank_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output logic             vld_o,
  output logic [BW-1:0]    bank_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  import rb_pkg::*;

  logic             vld_q, vld_d;
  logic [BW-1:0]    bank_q, bank_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [2:0]       left_q, left_d;
  logic             full_pg;
  logic [COL_W-1:0] mask, col_inc;

  assign full_pg = (bl_code_i == BLC_FP);
  assign mask    = full_pg ? LAST_COL : COL_W'(fixed_mask(bl_code_i));
  assign col_inc = col_q + COL_W'(1);

  always_comb begin
    vld_d  = vld_q;
    bank_d = bank_q;
    row_d  = row_q;
    col_d  = col_q;
    left_d = left_q;
    if (start_i) begin
      vld_d  = 1'b1;
      bank_d = bank_i;
      row_d  = row_i;
      col_d  = col_i;
      left_d = fixed_mask(bl_code_i);
    end else if (stop_i) begin
      vld_d = 1'b0;
    end else if (vld_q) begin
      if (!full_pg && (left_q == 3'd0)) begin
        vld_d = 1'b0;
      end else begin
        col_d  = (col_q & ~mask) | (col_inc & mask);
        left_d = left_q - 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      left_q <= '0;
    end else begin
      vld_q  <= vld_d;
      bank_q <= bank_d;
      row_q  <= row_d;
      col_q  <= col_d;
      left_q <= left_d;
    end
  end

  assign vld_o  = vld_q;
  assign bank_o = bank_q;
  assign row_o  = row_q;
  assign col_o  = col_q;

  // R3
  blk_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !start_i && !stop_i && !full_pg && (left_q != 3'd0))
      |=> ((col_q & ~mask) == ($past(col_q) & ~mask)));
  // R6
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && full_pg && !start_i && !stop_i && (col_q == LAST_COL))
      |=> (vld_q && (col_q == '0)));
  // R2
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !full_pg && (left_q == 3'd0) && !start_i) |=> !vld_q);

endmodule

// File: rtl/rb_lat_pipe.sv
module rb_lat_pipe #(
  parameter int MAX_CL = 3,
  parameter int W      = 10,
  localparam int CLW   = $clog2(MAX_CL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CLW-1:0] cl_i,
  input  logic           vld_i,
  input  logic [W-1:0]   col_i,
  output logic           vld_o,
  output logic [W-1:0]   col_o
);

  logic [MAX_CL:0] v;
  logic [W-1:0]    c [MAX_CL+1];

  assign v[0] = vld_i;
  assign c[0] = col_i;

  for (genvar k = 1; k <= MAX_CL; k++) begin : g_stage
    logic [W-1:0] c_d;
    // data stage loads only behind a live beat
    always_comb begin
      c_d = c[k];
      if (v[k-1]) c_d = c[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v[k] <= 1'b0;
        c[k] <= '0;
      end else begin
        v[k] <= v[k-1];
        c[k] <= c_d;
      end
    end
  end

  assign vld_o = v[cl_i];
  assign col_o = c[cl_i];

  // R1
  lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && (cl_i == CLW'(2))) |-> $past(vld_i, 2));
  // R1
  lat_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && (cl_i == CLW'(3))) |-> $past(vld_i, 3));

endmodule

// File: rtl/rd_burst_seq.sv
module rd_burst_seq #(
  parameter int NB     = 4,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 10,
  parameter int TRCD   = 3,
  parameter int MAX_CL = 3,
  localparam int BW    = $clog2(NB),
  localparam int CLW   = $clog2(MAX_CL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ld,
  input  logic             mode_cl3,
  input  logic [2:0]       mode_bl,
  input  logic             cmd_act,
  input  logic             cmd_rd,
  input  logic             cmd_bst,
  input  logic [BW-1:0]    cmd_bank,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic [COL_W-1:0] cmd_col,
  output logic             beat_vld,
  output logic [BW-1:0]    beat_bank,
  output logic [ROW_W-1:0] beat_row,
  output logic [COL_W-1:0] beat_col,
  output logic             dq_oe,
  output logic [COL_W-1:0] dq_col,
  output logic             rd_err
);

  logic [CLW-1:0]   cl_q, cl_d;
  logic [2:0]       bl_q, bl_d;
  logic             err_q, err_d;
  logic             bank_ready, rd_ok;
  logic [ROW_W-1:0] open_row;

  always_comb begin
    cl_d = cl_q;
    bl_d = bl_q;
    if (mode_ld) begin
      cl_d = mode_cl3 ? CLW'(3) : CLW'(2);
      bl_d = mode_bl;
    end
  end

  assign rd_ok = cmd_rd && bank_ready;
  assign err_d = cmd_rd && !bank_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_q  <= CLW'(2);
      bl_q  <= 3'd0;
      err_q <= 1'b0;
    end else begin
      cl_q  <= cl_d;
      bl_q  <= bl_d;
      err_q <= err_d;
    end
  end

  rb_bank_table #(.NB(NB), .ROW_W(ROW_W), .TRCD(TRCD)) u_banks (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_i      (cmd_act),
    .act_bank_i (cmd_bank),
    .act_row_i  (cmd_row),
    .q_bank_i   (cmd_bank),
    .q_ready_o  (bank_ready),
    .q_row_o    (open_row)
  );

  rb_col_gen #(.NB(NB), .ROW_W(ROW_W), .COL_W(COL_W)) u_cols (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (rd_ok),
    .stop_i    (cmd_bst),
    .bl_code_i (bl_q),
    .bank_i    (cmd_bank),
    .row_i     (open_row),
    .col_i     (cmd_col),
    .vld_o     (beat_vld),
    .bank_o    (beat_bank),
    .row_o     (beat_row),
    .col_o     (beat_col)
  );

  rb_lat_pipe #(.MAX_CL(MAX_CL), .W(COL_W)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .cl_i  (cl_q),
    .vld_i (beat_vld),
    .col_i (beat_col),
    .vld_o (dq_oe),
    .col_o (dq_col)
  );

  assign rd_err = err_q;

  // input rule: one command per cycle
  cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_act, cmd_rd, cmd_bst}));
  // R5
  stop_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_bst && !cmd_rd) |=> !beat_vld);
  // R9
  err_nobeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> !$rose(beat_vld));
  // R10
  beat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_vld) |-> $past(cmd_rd));

endmodule

// File: tb/sim_rd_burst_seq.sv
module sim_rd_burst_seq;

  localparam int COL_W = 10;
  localparam int LAST  = (1 << COL_W) - 1;
  localparam int TRCD  = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_ld, mode_cl3;
  logic [2:0]  mode_bl;
  logic        cmd_act, cmd_rd, cmd_bst;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_row;
  logic [9:0]  cmd_col;
  logic        beat_vld, dq_oe, rd_err;
  logic [1:0]  beat_bank;
  logic [11:0] beat_row;
  logic [9:0]  beat_col, dq_col;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  rd_burst_seq u0 (
    .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_cl3(mode_cl3),
    .mode_bl(mode_bl), .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_bst(cmd_bst),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .beat_vld(beat_vld), .beat_bank(beat_bank), .beat_row(beat_row),
    .beat_col(beat_col), .dq_oe(dq_oe), .dq_col(dq_col), .rd_err(rd_err)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_col(input int start, input int i, input int len);
    int m;
    m = (len == 0) ? LAST : len - 1;
    return ((start & ~m) | ((start + i) & m)) & LAST;
  endfunction

  task automatic set_mode(input bit cl3, input int code);
    mode_ld = 1'b1; mode_cl3 = cl3; mode_bl = 3'(code);
    tick();
    mode_ld = 1'b0;
  endtask

  task automatic activate(input int bank, input int row);
    cmd_act = 1'b1; cmd_bank = 2'(bank); cmd_row = 12'(row);
    tick();
    cmd_act = 1'b0;
  endtask

  // one read, checked beat by beat on the bus; bst_at < 0 means no stop
  task automatic run_burst(input int bank, input int col, input int row,
                           input int cl, input int len, input int bst_at,
                           input string req);
    int n;
    bit eo;
    n = len;
    if (bst_at >= 0 && (len == 0 || bst_at + 1 < len)) n = bst_at + 1;
    cmd_rd = 1'b1; cmd_bank = 2'(bank); cmd_col = 10'(col);
    tick();
    cmd_rd = 1'b0;
    // R10 start beat fields
    check(beat_vld == 1'b1, "R10 beat_vld", int'(beat_vld), 1);
    check(beat_bank == 2'(bank), "R10 beat_bank", int'(beat_bank), bank);
    check(beat_row == 12'(row), "R10 beat_row", int'(beat_row), row);
    check(beat_col == 10'(col), "R10 beat_col", int'(beat_col), col);
    check(rd_err == 1'b0, "R9 no err on valid read", int'(rd_err), 0);
    for (int c = 0; c < cl + n + 2; c++) begin
      eo = (c >= cl) && (c < cl + n);
      check(dq_oe == eo, req, int'(dq_oe), int'(eo));
      if (eo)
        check(int'(dq_col) == exp_col(col, c - cl, len), req, int'(dq_col),
              exp_col(col, c - cl, len));
      if (c == bst_at) cmd_bst = 1'b1;
      tick();
      cmd_bst = 1'b0;
    end
  endtask

  task automatic t_reset();
    // R11
    check(beat_vld == 1'b0, "R11 beat_vld", int'(beat_vld), 0);
    check(dq_oe == 1'b0, "R11 dq_oe", int'(dq_oe), 0);
    check(rd_err == 1'b0, "R11 rd_err", int'(rd_err), 0);
  endtask

  task automatic t_unopened();
    // R9 read to bank 3 which was never opened
    cmd_rd = 1'b1; cmd_bank = 2'd3; cmd_col = 10'd5;
    tick();
    cmd_rd = 1'b0;
    check(rd_err == 1'b1, "R9 err flag", int'(rd_err), 1);
    check(beat_vld == 1'b0, "R9 no beat", int'(beat_vld), 0);
    tick();
    check(rd_err == 1'b0, "R9 err one cycle", int'(rd_err), 0);
    for (int c = 0; c < 4; c++) begin
      check(dq_oe == 1'b0, "R9 bus idle", int'(dq_oe), 0);
      tick();
    end
  endtask

  task automatic t_trcd();
    set_mode(1'b0, 0);
    activate(2, 'h055);
    repeat (TRCD - 2) tick();
    // R8 one cycle early: rejected
    cmd_rd = 1'b1; cmd_bank = 2'd2; cmd_col = 10'd9;
    tick();
    cmd_rd = 1'b0;
    check(rd_err == 1'b1, "R8 early read err", int'(rd_err), 1);
    check(beat_vld == 1'b0, "R8 early read no beat", int'(beat_vld), 0);
    // R8 exactly TRCD after the open: accepted
    run_burst(2, 9, 'h055, 2, 1, -1, "R8 R2 BL1 at TRCD");
  endtask

  task automatic t_interrupt();
    int ec;
    bit eo;
    set_mode(1'b0, 3);
    cmd_rd = 1'b1; cmd_bank = 2'd0; cmd_col = 10'd0;
    tick();
    cmd_rd = 1'b0;
    for (int c = 0; c < 15; c++) begin
      // R7 old words 0,1,2 at cycles 2..4, new words 40..47 at cycles 5..12
      eo = (c >= 2) && (c <= 12);
      ec = (c <= 4) ? c - 2 : 40 + c - 5;
      check(dq_oe == eo, "R7 no gap", int'(dq_oe), int'(eo));
      if (eo) check(int'(dq_col) == ec, "R7 word order", int'(dq_col), ec);
      if (c == 2) begin
        cmd_rd = 1'b1; cmd_bank = 2'd1; cmd_col = 10'd40;
      end
      tick();
      cmd_rd = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; mode_ld = 1'b0; mode_cl3 = 1'b0; mode_bl = 3'd0;
    cmd_act = 1'b0; cmd_rd = 1'b0; cmd_bst = 1'b0;
    cmd_bank = 2'd0; cmd_row = 12'd0; cmd_col = 10'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_unopened();
    activate(0, 'h123);
    activate(1, 'h0ab);
    repeat (TRCD) tick();
    set_mode(1'b0, 2);
    run_burst(0, 6, 'h123, 2, 4, -1, "R1 R3 R4 BL4 CL2");
    set_mode(1'b1, 3);
    run_burst(1, 13, 'h0ab, 3, 8, -1, "R1 R3 R4 BL8 CL3");
    set_mode(1'b0, 1);
    run_burst(0, 7, 'h123, 2, 2, -1, "R2 R3 BL2");
    set_mode(1'b1, 5);
    run_burst(1, 3, 'h0ab, 3, 1, -1, "R2 reserved code as BL1");
    set_mode(1'b0, 7);
    run_burst(0, LAST - 2, 'h123, 2, 0, 5, "R6 R5 full page wrap and stop");
    set_mode(1'b1, 7);
    run_burst(1, 100, 'h0ab, 3, 0, 12, "R6 R5 long full page CL3");
    set_mode(1'b1, 3);
    run_burst(0, 16, 'h123, 3, 8, 2, "R5 stop in BL8");
    t_interrupt();
    t_trcd();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule